// File: doc/BRIEF.md
# Shader Operand Swizzle and Write-Mask Unit

This block sits between a shader register file and the arithmetic datapath. Each accepted operation carries a 31-bit operand descriptor and up to three raw source register indices. It also carries a relative-addressing select and the current values of the three address registers (two general offsets and the loop counter). The unit resolves the effective register index of each source and drives it on a read-index port. It then takes the four-lane vectors the register file returns in the same cycle and reorders their lanes by the per-source selector. It optionally flips the sign bit of every lane and decodes the destination write enables. The result is registered. Lanes are 32-bit IEEE-754 single-precision words, and lane k sits at bits [32k+31:32k], so lane 0 (x) is the least significant word.

Both the input and the output are valid/ready streams. An input transfer happens on a rising edge with `in_valid` and `in_ready` both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new input is taken. The register file read is combinational: the `srcN_vec` inputs must reflect `rd_idxN` within the same cycle. The out-of-range flag is a plain status pin and does not take part in the handshake.

Top module: `opnd_shape_unit`

## Requirements
- R1: The registered write enables map descriptor bits in reverse: `wr_en[0]` (x) = desc[3], `wr_en[1]` (y) = desc[2], `wr_en[2]` (z) = desc[1], `wr_en[3]` (w) = desc[0].
- R2: Source 1 uses selector desc[12:5], source 2 uses desc[21:14] and source 3 uses desc[30:23]. Output lane c takes input lane `sel[7-2c:6-2c]`, with code 0=x, 1=y, 2=z and 3=w. Selector 0x1B gives the identity order, 0x55 copies y into all lanes, and 0xE4 reverses the lanes.
- R3: The negate bits are desc[4] for source 1, desc[13] for source 2 and desc[22] for source 3. A set negate bit inverts bit 31 of all four lanes after the lane reordering and leaves bits 30:0 unchanged.
- R4: `rel_sel` picks what is added to one source index: 0 adds nothing, 1 adds a0x, 2 adds a0y and 3 adds the loop counter. The offsets are two's complement. The addition goes to source 1 when `rel_on_src2`=0 and to source 2 when it is 1. The other sources stay unchanged.
- R5: The source 2 and source 3 index inputs are 5 bits wide and are zero-extended to the 7-bit index space. Without relative addressing they can therefore reach only indices 0x00–0x1F.
- R6: An effective index below 0 or above 127 wraps modulo 128. Accepting such a transfer sets `oor_flag` on the next cycle, and the flag stays set until reset.
- R7: `out_valid` rises on the edge after an accepted input, with the shaped operands and write enables of that input. `in_ready` = !`out_valid` || `out_ready`.
- R8: While `out_valid`=1 and `out_ready`=0, all outputs hold and no input is accepted.
- R9: After reset, `out_valid`=0, `oor_flag`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Unit can accept an operation |
| desc | input | 31 | Operand descriptor |
| src1_raw | input | 7 | Source 1 register index |
| src2_raw | input | 5 | Source 2 register index |
| src3_raw | input | 5 | Source 3 register index |
| rel_sel | input | 2 | Relative address register select |
| rel_on_src2 | input | 1 | Apply the relative offset to source 2 instead of source 1 |
| a0x | input | 8 | Address register x (signed) |
| a0y | input | 8 | Address register y (signed) |
| aloop | input | 8 | Loop counter (signed) |
| rd_idx1 | output | 7 | Effective read index, source 1 |
| rd_idx2 | output | 7 | Effective read index, source 2 |
| rd_idx3 | output | 7 | Effective read index, source 3 |
| src1_vec | input | 128 | Register file data for rd_idx1 |
| src2_vec | input | 128 | Register file data for rd_idx2 |
| src3_vec | input | 128 | Register file data for rd_idx3 |
| out_valid | output | 1 | Shaped operands valid |
| out_ready | input | 1 | Consumer accepts operands |
| op1 | output | 128 | Shaped source 1 |
| op2 | output | 128 | Shaped source 2 |
| op3 | output | 128 | Shaped source 3 |
| wr_en | output | 4 | Destination lane write enables |
| oor_flag | output | 1 | Sticky out-of-range index flag |

## Verification
The bench models the register file as a pure function of the read index, so a wrong effective index shows up as wrong lane contents. It uses asymmetric selectors (0xE4, 0x55, 0x1B) and an asymmetric write mask: a design that reads selector fields or mask bits in forward order would swap lanes or enables and fail. It sends a negative offset, a wrap past 127 and relative addressing on source 2. These catch a design that zero-extends the offset, saturates, forgets the sticky flag or adds the offset to the wrong source. A stalled output with a second request pending checks that a design which overwrites its register or accepts early changes the held operands.

// File: rtl/opnd_shape_pkg.sv
package opnd_shape_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 32;
  localparam int VEC_W  = LANES * LANE_W;
  localparam int IDX_W  = 7;
  localparam int SEL_W  = 2 * LANES;
  localparam int NSRC   = 3;

  typedef enum logic [1:0] {
    REL_NONE = 2'd0,
    REL_A0X  = 2'd1,
    REL_A0Y  = 2'd2,
    REL_LOOP = 2'd3
  } rel_sel_e;
endpackage

// File: rtl/opnd_swz.sv
module opnd_swz #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*LANES-1:0]      sel,
  input  logic                    neg,
  input  logic [LANES*LANE_W-1:0] vin,
  output logic [LANES*LANE_W-1:0] vout
);
  localparam int CW = $clog2(LANES);

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    logic [CW-1:0]     code;
    logic [LANE_W-1:0] picked;
    assign code   = sel[2*(LANES-1-c) +: CW];
    assign picked = vin[int'(code)*LANE_W +: LANE_W];
    assign vout[c*LANE_W +: LANE_W] = {picked[LANE_W-1] ^ neg, picked[LANE_W-2:0]};
  end

  // identity selector passes vector through untouched (R2)
  assert_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 8'h1B && !neg) |-> (vout == vin));

  // broadcast of x lane when selector is all zero (R2)
  assert_bcast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 8'h00) |-> (vout[LANE_W-2:0] == vin[LANE_W-2:0] &&
                        vout[LANES*LANE_W-2 -: LANE_W-1] == vin[LANE_W-2:0]));
endmodule

// File: rtl/opnd_addr.sv
module opnd_addr
  import opnd_shape_pkg::*;
#(
  parameter int IW = 7,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx,
  input  rel_sel_e      rel,
  input  logic          apply,
  input  logic [AW-1:0] a0x,
  input  logic [AW-1:0] a0y,
  input  logic [AW-1:0] aloop,
  output logic [IW-1:0] eff,
  output logic          oor
);
  localparam int SW = ((AW > IW) ? AW : IW) + 2;
  localparam logic signed [SW-1:0] MAXI = SW'((1 << IW) - 1);

  logic [AW-1:0]        off_raw;
  logic signed [SW-1:0] off, sum;

  always_comb begin
    off_raw = '0;
    if (apply) begin
      unique case (rel)
        REL_A0X:  off_raw = a0x;
        REL_A0Y:  off_raw = a0y;
        REL_LOOP: off_raw = aloop;
        default:  off_raw = '0;
      endcase
    end
    off = {{(SW-AW){off_raw[AW-1]}}, off_raw};
    sum = $signed({{(SW-IW){1'b0}}, idx}) + off;
    eff = sum[IW-1:0];
    oor = sum[SW-1] || (sum > MAXI);
  end

  // no relative addressing leaves index unchanged (R4)
  assert_noadd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply || rel == REL_NONE) |-> (eff == idx && !oor));

  // range error only possible with an active offset (R6)
  assert_oor_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oor |-> (apply && rel != REL_NONE));
endmodule

// File: rtl/opnd_shape_unit.sv
module opnd_shape_unit
  import opnd_shape_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [30:0]       desc,
  input  logic [IDX_W-1:0]  src1_raw,
  input  logic [4:0]        src2_raw,
  input  logic [4:0]        src3_raw,
  input  logic [1:0]        rel_sel,
  input  logic              rel_on_src2,
  input  logic [AW-1:0]     a0x,
  input  logic [AW-1:0]     a0y,
  input  logic [AW-1:0]     aloop,
  output logic [IDX_W-1:0]  rd_idx1,
  output logic [IDX_W-1:0]  rd_idx2,
  output logic [IDX_W-1:0]  rd_idx3,
  input  logic [VEC_W-1:0]  src1_vec,
  input  logic [VEC_W-1:0]  src2_vec,
  input  logic [VEC_W-1:0]  src3_vec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  op1,
  output logic [VEC_W-1:0]  op2,
  output logic [VEC_W-1:0]  op3,
  output logic [LANES-1:0]  wr_en,
  output logic              oor_flag
);
  localparam int FIELD_W = SEL_W + 1;
  localparam int MASK_W  = LANES;

  rel_sel_e rel;
  logic     oor1, oor2, in_fire;
  logic [IDX_W-1:0] s2_ext;

  assign rel     = rel_sel_e'(rel_sel);
  assign s2_ext  = IDX_W'(src2_raw);
  assign rd_idx3 = IDX_W'(src3_raw);

  opnd_addr #(.IW(IDX_W), .AW(AW)) u_addr1 (
    .clk(clk), .rst_n(rst_n), .idx(src1_raw), .rel(rel), .apply(!rel_on_src2),
    .a0x(a0x), .a0y(a0y), .aloop(aloop), .eff(rd_idx1), .oor(oor1));

  opnd_addr #(.IW(IDX_W), .AW(AW)) u_addr2 (
    .clk(clk), .rst_n(rst_n), .idx(s2_ext), .rel(rel), .apply(rel_on_src2),
    .a0x(a0x), .a0y(a0y), .aloop(aloop), .eff(rd_idx2), .oor(oor2));

  logic [VEC_W-1:0] vin_a  [NSRC];
  logic [VEC_W-1:0] vout_a [NSRC];
  assign vin_a[0] = src1_vec;
  assign vin_a[1] = src2_vec;
  assign vin_a[2] = src3_vec;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int BASE = MASK_W + s * FIELD_W;
    opnd_swz #(.LANES(LANES), .LANE_W(LANE_W)) u_swz (
      .clk(clk), .rst_n(rst_n),
      .sel(desc[BASE+1 +: SEL_W]), .neg(desc[BASE]),
      .vin(vin_a[s]), .vout(vout_a[s]));
  end

  logic [LANES-1:0] wr_next;
  for (genvar c = 0; c < LANES; c++) begin : g_wr
    assign wr_next[c] = desc[MASK_W-1-c];
  end

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      op1       <= '0;
      op2       <= '0;
      op3       <= '0;
      wr_en     <= '0;
      oor_flag  <= 1'b0;
    end else begin
      if (in_fire) begin
        out_valid <= 1'b1;
        op1       <= vout_a[0];
        op2       <= vout_a[1];
        op3       <= vout_a[2];
        wr_en     <= wr_next;
        if (oor1 || oor2) oor_flag <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // accepted input produces valid output next cycle (R7)
  assert_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // stalled output holds its payload (R8)
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(op1) && $stable(op2) &&
                                   $stable(op3) && $stable(wr_en)));

  // out-of-range flag never clears without reset (R6)
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oor_flag |=> oor_flag);

  // no acceptance while stalled (R8)
  assert_noaccept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/opnd_shape_unit_tb_top.sv
module opnd_shape_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         in_valid = 1'b0, out_ready = 1'b1, rel_on_src2 = 1'b0;
  logic         in_ready, out_valid, oor_flag;
  logic [30:0]  desc = '0;
  logic [6:0]   src1_raw = '0;
  logic [4:0]   src2_raw = '0, src3_raw = '0;
  logic [1:0]   rel_sel = '0;
  logic [7:0]   a0x = '0, a0y = '0, aloop = '0;
  logic [6:0]   rd_idx1, rd_idx2, rd_idx3;
  logic [127:0] src1_vec, src2_vec, src3_vec, op1, op2, op3;
  logic [3:0]   wr_en;

  int n_chk = 0, n_bad = 0;

  function automatic logic [127:0] mkvec(input logic [6:0] idx);
    logic [127:0] v;
    for (int k = 0; k < 4; k++)
      v[k*32 +: 32] = {idx[0], idx, 8'(k + 1), 16'hC0DE};
    return v;
  endfunction

  function automatic logic [127:0] shape(input logic [127:0] v, input logic [7:0] sel,
                                         input logic neg);
    logic [127:0] r;
    for (int c = 0; c < 4; c++) begin
      logic [1:0]  code;
      logic [31:0] l;
      code = sel[7-2*c -: 2];
      l = v[code*32 +: 32];
      l[31] = l[31] ^ neg;
      r[c*32 +: 32] = l;
    end
    return r;
  endfunction

  function automatic logic [30:0] mkdesc(input logic [3:0] m, input logic n1,
      input logic [7:0] s1, input logic n2, input logic [7:0] s2,
      input logic n3, input logic [7:0] s3);
    return {s3, n3, s2, n2, s1, n1, m};
  endfunction

  assign src1_vec = mkvec(rd_idx1);
  assign src2_vec = mkvec(rd_idx2);
  assign src3_vec = mkvec(rd_idx3);

  opnd_shape_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .desc(desc), .src1_raw(src1_raw), .src2_raw(src2_raw), .src3_raw(src3_raw),
    .rel_sel(rel_sel), .rel_on_src2(rel_on_src2), .a0x(a0x), .a0y(a0y), .aloop(aloop),
    .rd_idx1(rd_idx1), .rd_idx2(rd_idx2), .rd_idx3(rd_idx3),
    .src1_vec(src1_vec), .src2_vec(src2_vec), .src3_vec(src3_vec),
    .out_valid(out_valid), .out_ready(out_ready), .op1(op1), .op2(op2), .op3(op3),
    .wr_en(wr_en), .oor_flag(oor_flag));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one op at negedge, check read indices, accept, check outputs
  task automatic send_op(input string req, input logic [30:0] d, input logic [6:0] s1,
      input logic [4:0] s2, input logic [4:0] s3, input logic [1:0] rs, input logic r2,
      input logic [6:0] e1, input logic [6:0] e2);
    @(negedge clk);
    desc = d; src1_raw = s1; src2_raw = s2; src3_raw = s3;
    rel_sel = rs; rel_on_src2 = r2; in_valid = 1'b1;
    #1;
    chk({req, " rd_idx1"}, 128'(rd_idx1), 128'(e1));
    chk({req, " rd_idx2"}, 128'(rd_idx2), 128'(e2));
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " out_valid R7"}, 128'(out_valid), 128'(1));
    chk({req, " op1"}, op1, shape(mkvec(e1), d[12:5], d[4]));
    chk({req, " op2"}, op2, shape(mkvec(e2), d[21:14], d[13]));
    chk({req, " op3"}, op3, shape(mkvec(7'(s3)), d[30:23], d[22]));
    chk({req, " wr_en R1"}, 128'(wr_en), 128'({d[0], d[1], d[2], d[3]}));
  endtask

  task automatic t_reset;
    chk("R9 out_valid", 128'(out_valid), 128'(0));
    chk("R9 oor_flag", 128'(oor_flag), 128'(0));
    chk("R9 in_ready", 128'(in_ready), 128'(1));
  endtask

  task automatic t_swizzle;
    send_op("R2 id/bcast/rev", mkdesc(4'b1010, 0, 8'h1B, 0, 8'h55, 0, 8'hE4),
            7'h10, 5'h12, 5'h13, 2'd0, 1'b0, 7'h10, 7'h12);
    send_op("R1 mask", mkdesc(4'b0001, 0, 8'h93, 0, 8'h00, 0, 8'hFF),
            7'h25, 5'h03, 5'h07, 2'd0, 1'b0, 7'h25, 7'h03);
  endtask

  task automatic t_negate;
    send_op("R3 neg1", mkdesc(4'hF, 1, 8'h1B, 0, 8'h1B, 0, 8'h1B),
            7'h21, 5'h11, 5'h02, 2'd0, 1'b0, 7'h21, 7'h11);
    send_op("R3 neg2 neg3", mkdesc(4'h6, 0, 8'hE4, 1, 8'h55, 1, 8'h39),
            7'h30, 5'h05, 5'h1E, 2'd0, 1'b0, 7'h30, 7'h05);
  endtask

  task automatic t_relative;
    a0x = 8'hFE; a0y = 8'd3; aloop = 8'd5;
    send_op("R4 a0y c8->c11", mkdesc(4'h8, 0, 8'h1B, 0, 8'h1B, 0, 8'h1B),
            7'h28, 5'h10, 5'h00, 2'd2, 1'b0, 7'h2B, 7'h10);
    send_op("R4 a0x negative", mkdesc(4'h8, 0, 8'h1B, 0, 8'h1B, 0, 8'h1B),
            7'h28, 5'h10, 5'h00, 2'd1, 1'b0, 7'h26, 7'h10);
    send_op("R4 R5 loop on src2", mkdesc(4'h8, 0, 8'h1B, 0, 8'hE4, 0, 8'h1B),
            7'h28, 5'h1F, 5'h00, 2'd3, 1'b1, 7'h28, 7'h24);
    send_op("R5 src2 plain", mkdesc(4'h8, 0, 8'h1B, 0, 8'h1B, 0, 8'h1B),
            7'h7F, 5'h1F, 5'h1F, 2'd0, 1'b1, 7'h7F, 7'h1F);
    chk("R6 no flag yet", 128'(oor_flag), 128'(0));
  endtask

  task automatic t_wrap;
    a0x = 8'd5;
    send_op("R6 wrap", mkdesc(4'hF, 0, 8'h1B, 0, 8'h1B, 0, 8'h1B),
            7'h7E, 5'h01, 5'h02, 2'd1, 1'b0, 7'h03, 7'h01);
    chk("R6 flag set", 128'(oor_flag), 128'(1));
    send_op("R6 clean after", mkdesc(4'hF, 0, 8'h1B, 0, 8'h1B, 0, 8'h1B),
            7'h10, 5'h01, 5'h02, 2'd0, 1'b0, 7'h10, 7'h01);
    chk("R6 flag sticky", 128'(oor_flag), 128'(1));
  endtask

  task automatic t_stall;
    logic [30:0] da, db;
    da = mkdesc(4'hC, 0, 8'hE4, 0, 8'h1B, 0, 8'h1B);
    db = mkdesc(4'h3, 1, 8'h55, 0, 8'h1B, 0, 8'h1B);
    @(negedge clk);
    out_ready = 1'b0; rel_sel = 2'd0;
    desc = da; src1_raw = 7'h11; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    desc = db; src1_raw = 7'h12;
    #1;
    chk("R7 in_ready low when full", 128'(in_ready), 128'(0));
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8 hold op1", op1, shape(mkvec(7'h11), 8'hE4, 1'b0));
    chk("R8 hold wr_en", 128'(wr_en), 128'(4'b0011));
    chk("R8 still valid", 128'(out_valid), 128'(1));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 next op1", op1, shape(mkvec(7'h12), 8'h55, 1'b1));
    chk("R7 next wr_en", 128'(wr_en), 128'(4'b1100));
    @(posedge clk);
    @(negedge clk);
    chk("R7 drained", 128'(out_valid), 128'(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_swizzle();
    t_negate();
    t_relative();
    t_wrap();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule